// File: doc/BRIEF.md
# Trace Control System Register Access Checker

This block rules on every system-register access that names one of two aliased instrumentation-trace control registers. One is owned by the hypervisor level and the other by the kernel level. Each cycle it takes the decoded instruction fields, the read/write direction, the current exception level and the relevant hypervisor, monitor and debug control bits. In the same cycle it returns a single one-hot verdict. The verdict is one of: undefined instruction, trap to EL2, trap to EL3, redirect to a memory slot, or access to one of the two physical registers.

The block also holds both 64-bit registers. For traps it reports the exception class and target level. For redirects it reports the memory offset. It drives the trace-enable controls that the hypervisor-level register supplies. Instruction fetch, exception entry and the memory access itself are left to neighbouring logic.

Top module: `itrace_sysreg_ctrl`

## Requirements
- R1: `verdict_o` is one-hot or zero. Bit 0 means undefined, bit 1 trap to EL2, bit 2 trap to EL3, bit 3 memory redirect, bit 4 hypervisor-register access and bit 5 kernel-register access. It is zero when `req_valid_i` is 0 or when the encoding names neither register. The hypervisor register is op0=3, op1=4, CRn=1, CRm=2, op2=3. The kernel register has the same fields except op1=0.
- R2: Any access from EL0 (`cur_el_i`=0) to either register is undefined.
- R3: An EL1 access to the hypervisor register traps to EL2 when `el2_en_i` and `nv_i` are both 1. Otherwise it is undefined.
- R4: An access at EL2, or an EL1 access to the kernel register, is undefined ahead of every other check under one condition. That condition is: `halted_i`, `el3_present_i` and `sdd_i` are all 1, parameter `SDD_EL3_PRIO` is 1, and `ite_en_i` is 0.
- R5: An EL1 access to the kernel register traps to EL2 when `el2_en_i` is 1, parameter `HAS_FGT2` is 1, and one of two bits is 0. The first is `fgt2_en_i` while `el3_present_i` is 1. The second is the direction's own trap bit: `fgt_rd_i` for reads, `fgt_wr_i` for writes. This check runs after R4 and before R6.
- R6: When `el3_present_i` is 1 and `ite_en_i` is 0, an access at EL1 or EL2 that survived the earlier checks traps to EL3. If `halted_i` and `sdd_i` are both 1, it is undefined instead.
- R7: An EL1 kernel-register access that passed R4 to R6, with `el2_en_i`, `nv2_i`, `nv1_i` and `nv_i` all 1, is redirected, and `mem_offset_o` is 0x888. Otherwise `mem_offset_o` is 0.
- R8: At EL2 the kernel name selects the hypervisor register when `e2h_i` is 1, and the kernel register otherwise. At EL1 the kernel name selects the kernel register. At EL2 and EL3 the hypervisor name selects the hypervisor register, and at EL3 the kernel name selects the kernel register.
- R9: On either trap, `ec_o` is 0x18 and `trap_el_o` is 2 or 3 to match the verdict. On every other verdict both are 0.
- R10: A write commits at the next clock edge, and only when the verdict is a register access. The hypervisor register keeps bits [1:0] and reads bits [63:2] as zero. The kernel register updates only the bits set in `KRN_WMASK` (default 0x3). On a read verdict `rdata_o` shows the selected register; otherwise it is 0.
- R11: After reset both registers read zero.
- R12: `el2_trace_en_o` equals hypervisor-register bit 1. `el0_trace_en_o` equals hypervisor-register bit 0 AND `tge_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| op0_i | input | 2 | Encoding op0 |
| op1_i | input | 3 | Encoding op1 |
| crn_i | input | 4 | Encoding CRn |
| crm_i | input | 4 | Encoding CRm |
| op2_i | input | 3 | Encoding op2 |
| is_write_i | input | 1 | 1 = register write, 0 = read |
| wdata_i | input | 64 | Write data |
| cur_el_i | input | 2 | Current exception level |
| el2_en_i | input | 1 | EL2 enabled in current state |
| el3_present_i | input | 1 | EL3 implemented |
| halted_i | input | 1 | PE in debug halt |
| sdd_i | input | 1 | Debug secure-disable bit |
| ite_en_i | input | 1 | Monitor enable for instrumentation trace access |
| fgt2_en_i | input | 1 | Monitor enable for second fine-grained trap set |
| fgt_rd_i | input | 1 | Kernel-register read trap bit (0 traps) |
| fgt_wr_i | input | 1 | Kernel-register write trap bit (0 traps) |
| nv_i | input | 1 | Nested virtualisation control |
| nv1_i | input | 1 | Nested virtualisation control 1 |
| nv2_i | input | 1 | Nested virtualisation control 2 |
| e2h_i | input | 1 | Host-at-EL2 alias control |
| tge_i | input | 1 | Trap-general-exceptions control |
| verdict_o | output | 6 | One-hot access verdict |
| ec_o | output | 6 | Exception class on trap |
| trap_el_o | output | 2 | Target level on trap |
| mem_offset_o | output | 12 | Memory slot offset on redirect |
| rdata_o | output | 64 | Read data |
| el2_trace_en_o | output | 1 | Trace enable at EL2 |
| el0_trace_en_o | output | 1 | Trace enable at EL0 under TGE |

## Verification
The assertions assume the control bits are steady levels sampled on the clock. They also assume `cur_el_i` names only a level at which the request is legal to present. An undriven or X input would make the one-hot check meaningless. The bench drives every input at the falling edge from a fixed-seed random stream. It biases the encoding towards the two register names and biases the halt, monitor and trap bits so that every branch of the priority chain is reached. Directed cases then pin the priority corners and the masked write.

// File: rtl/itrace_pkg.sv
package itrace_pkg;
  localparam int VW = 6;
  localparam logic [VW-1:0] V_NONE  = 6'b000000;
  localparam logic [VW-1:0] V_UNDEF = 6'b000001;
  localparam logic [VW-1:0] V_TRAP2 = 6'b000010;
  localparam logic [VW-1:0] V_TRAP3 = 6'b000100;
  localparam logic [VW-1:0] V_MEM   = 6'b001000;
  localparam logic [VW-1:0] V_HYP   = 6'b010000;
  localparam logic [VW-1:0] V_KRN   = 6'b100000;
  localparam logic [5:0]  EC_ITRACE = 6'h18;
  localparam logic [11:0] NV_SLOT   = 12'h888;
  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;
endpackage

// File: rtl/itrace_access_decode.sv
module itrace_access_decode
  import itrace_pkg::*;
#(
  parameter bit SDD_EL3_PRIO = 1'b1,
  parameter bit HAS_FGT2     = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          hit_hyp_i,
  input  logic          hit_krn_i,
  input  logic          is_write_i,
  input  logic [1:0]    cur_el_i,
  input  logic          el2_en_i,
  input  logic          el3_present_i,
  input  logic          halted_i,
  input  logic          sdd_i,
  input  logic          ite_en_i,
  input  logic          fgt2_en_i,
  input  logic          fgt_rd_i,
  input  logic          fgt_wr_i,
  input  logic          nv_i,
  input  logic          nv1_i,
  input  logic          nv2_i,
  input  logic          e2h_i,
  output logic [VW-1:0] verdict_o
);
  logic          prio_undef, ite_block, fgt_bit, live;
  logic [VW-1:0] ite_res;

  assign live       = req_valid_i && (hit_hyp_i || hit_krn_i);
  assign prio_undef = halted_i && el3_present_i && sdd_i && SDD_EL3_PRIO && !ite_en_i;
  assign ite_block  = el3_present_i && !ite_en_i;
  assign ite_res    = (halted_i && sdd_i) ? V_UNDEF : V_TRAP3;
  assign fgt_bit    = is_write_i ? fgt_wr_i : fgt_rd_i;

  always_comb begin
    verdict_o = V_NONE;
    if (live) begin
      unique case (lvl_e'(cur_el_i))
        LVL0: verdict_o = V_UNDEF;
        LVL1: begin
          if (hit_hyp_i)                                    verdict_o = (el2_en_i && nv_i) ? V_TRAP2 : V_UNDEF;
          else if (prio_undef)                              verdict_o = V_UNDEF;
          else if (el2_en_i && HAS_FGT2 && el3_present_i && !fgt2_en_i) verdict_o = V_TRAP2;
          else if (el2_en_i && HAS_FGT2 && !fgt_bit)        verdict_o = V_TRAP2;
          else if (ite_block)                               verdict_o = ite_res;
          else if (el2_en_i && nv2_i && nv1_i && nv_i)      verdict_o = V_MEM;
          else                                              verdict_o = V_KRN;
        end
        LVL2: begin
          if (prio_undef)      verdict_o = V_UNDEF;
          else if (ite_block)  verdict_o = ite_res;
          else if (hit_hyp_i)  verdict_o = V_HYP;
          else                 verdict_o = e2h_i ? V_HYP : V_KRN;
        end
        default: verdict_o = hit_hyp_i ? V_HYP : V_KRN;
      endcase
    end
  end

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(verdict_o) && (live || verdict_o == V_NONE));
  p_el0_undef_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cur_el_i == 2'd0) |-> verdict_o == V_UNDEF);
  p_el1_hyp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && hit_hyp_i && cur_el_i == 2'd1) |-> (verdict_o == V_TRAP2 || verdict_o == V_UNDEF));
  p_sdd_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && prio_undef && (cur_el_i == 2'd2 || (cur_el_i == 2'd1 && hit_krn_i))) |-> verdict_o == V_UNDEF);
  p_el3_trap_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == V_TRAP3) |-> (el3_present_i && !ite_en_i));
endmodule

// File: rtl/itrace_ctl_regs.sv
module itrace_ctl_regs #(
  parameter int          DW        = 64,
  parameter logic [63:0] KRN_WMASK = 64'h3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hyp_i,
  input  logic          wr_krn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [1:0]    hyp_q_o,
  output logic [DW-1:0] krn_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hyp_q_o <= '0;
    else if (wr_hyp_i) hyp_q_o <= wdata_i[1:0];
  end

  for (genvar b = 0; b < DW; b++) begin : g_krn
    if (KRN_WMASK[b]) begin : g_rw
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (wr_krn_i) q <= wdata_i[b];
      end
      assign krn_q_o[b] = q;
    end else begin : g_ro
      assign krn_q_o[b] = 1'b0;
    end
  end

  p_hyp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hyp_i |=> $stable(hyp_q_o));
  p_krn_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_krn_i |=> $stable(krn_q_o));
endmodule

// File: rtl/itrace_sysreg_ctrl.sv
module itrace_sysreg_ctrl
  import itrace_pkg::*;
#(
  parameter bit          SDD_EL3_PRIO = 1'b1,
  parameter bit          HAS_FGT2     = 1'b1,
  parameter logic [63:0] KRN_WMASK    = 64'h3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [1:0]  op0_i,
  input  logic [2:0]  op1_i,
  input  logic [3:0]  crn_i,
  input  logic [3:0]  crm_i,
  input  logic [2:0]  op2_i,
  input  logic        is_write_i,
  input  logic [63:0] wdata_i,
  input  logic [1:0]  cur_el_i,
  input  logic        el2_en_i,
  input  logic        el3_present_i,
  input  logic        halted_i,
  input  logic        sdd_i,
  input  logic        ite_en_i,
  input  logic        fgt2_en_i,
  input  logic        fgt_rd_i,
  input  logic        fgt_wr_i,
  input  logic        nv_i,
  input  logic        nv1_i,
  input  logic        nv2_i,
  input  logic        e2h_i,
  input  logic        tge_i,
  output logic [5:0]  verdict_o,
  output logic [5:0]  ec_o,
  output logic [1:0]  trap_el_o,
  output logic [11:0] mem_offset_o,
  output logic [63:0] rdata_o,
  output logic        el2_trace_en_o,
  output logic        el0_trace_en_o
);
  logic        enc_common, hit_hyp, hit_krn;
  logic [1:0]  hyp_q;
  logic [63:0] krn_q;

  assign enc_common = (op0_i == 2'b11) && (crn_i == 4'b0001) && (crm_i == 4'b0010) && (op2_i == 3'b011);
  assign hit_hyp    = enc_common && (op1_i == 3'b100);
  assign hit_krn    = enc_common && (op1_i == 3'b000);

  itrace_access_decode #(.SDD_EL3_PRIO(SDD_EL3_PRIO), .HAS_FGT2(HAS_FGT2)) u_dec (
    .clk_i, .rst_ni, .req_valid_i,
    .hit_hyp_i(hit_hyp), .hit_krn_i(hit_krn),
    .is_write_i, .cur_el_i, .el2_en_i, .el3_present_i, .halted_i, .sdd_i,
    .ite_en_i, .fgt2_en_i, .fgt_rd_i, .fgt_wr_i, .nv_i, .nv1_i, .nv2_i, .e2h_i,
    .verdict_o
  );

  itrace_ctl_regs #(.DW(64), .KRN_WMASK(KRN_WMASK)) u_regs (
    .clk_i, .rst_ni,
    .wr_hyp_i(verdict_o == V_HYP && is_write_i),
    .wr_krn_i(verdict_o == V_KRN && is_write_i),
    .wdata_i,
    .hyp_q_o(hyp_q),
    .krn_q_o(krn_q)
  );

  always_comb begin
    ec_o         = '0;
    trap_el_o    = '0;
    mem_offset_o = '0;
    rdata_o      = '0;
    unique case (verdict_o)
      V_TRAP2: begin ec_o = EC_ITRACE; trap_el_o = 2'd2; end
      V_TRAP3: begin ec_o = EC_ITRACE; trap_el_o = 2'd3; end
      V_MEM:   mem_offset_o = NV_SLOT;
      V_HYP:   if (!is_write_i) rdata_o = {62'b0, hyp_q};
      V_KRN:   if (!is_write_i) rdata_o = krn_q;
      default: ;
    endcase
  end

  assign el2_trace_en_o = hyp_q[1];
  assign el0_trace_en_o = hyp_q[0] && tge_i;

  p_trap_syndrome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == V_TRAP2 || verdict_o == V_TRAP3) |-> (ec_o == 6'h18 && trap_el_o >= 2'd2));
  p_redirect_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == V_MEM) |-> (hit_krn && cur_el_i == 2'd1 && mem_offset_o == 12'h888));
  p_hyp_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == V_HYP) |-> rdata_o[63:2] == 62'b0);
endmodule

// File: tb/tb_itrace_sysreg_ctrl.sv
module tb_itrace_sysreg_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [63:0] MASK = 64'h3;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i, is_write_i;
  logic [1:0] op0_i, cur_el_i;
  logic [2:0] op1_i, op2_i;
  logic [3:0] crn_i, crm_i;
  logic [63:0] wdata_i;
  logic el2_en_i, el3_present_i, halted_i, sdd_i, ite_en_i, fgt2_en_i, fgt_rd_i, fgt_wr_i;
  logic nv_i, nv1_i, nv2_i, e2h_i, tge_i;
  logic [5:0] verdict_o, ec_o;
  logic [1:0] trap_el_o;
  logic [11:0] mem_offset_o;
  logic [63:0] rdata_o;
  logic el2_trace_en_o, el0_trace_en_o;

  int checks = 0, errors = 0;
  logic [1:0] hyp_m;
  logic [63:0] krn_m;
  string rule;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  itrace_sysreg_ctrl dut (.*);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_verdict();
    logic hh, hk, pu, ib;
    logic [5:0] ir;
    hh = req_valid_i && op0_i == 3 && op1_i == 4 && crn_i == 1 && crm_i == 2 && op2_i == 3;
    hk = req_valid_i && op0_i == 3 && op1_i == 0 && crn_i == 1 && crm_i == 2 && op2_i == 3;
    pu = halted_i && el3_present_i && sdd_i && !ite_en_i;
    ib = el3_present_i && !ite_en_i;
    ir = (halted_i && sdd_i) ? 6'd1 : 6'd4;
    if (!hh && !hk) begin rule = "R1"; return 6'd0; end
    if (cur_el_i == 0) begin rule = "R2"; return 6'd1; end
    if (cur_el_i == 1 && hh) begin rule = "R3"; return (el2_en_i && nv_i) ? 6'd2 : 6'd1; end
    if (cur_el_i == 3) begin rule = "R8"; return hh ? 6'd16 : 6'd32; end
    if (pu) begin rule = "R4"; return 6'd1; end
    if (cur_el_i == 1) begin
      if (el2_en_i && el3_present_i && !fgt2_en_i) begin rule = "R5"; return 6'd2; end
      if (el2_en_i && !(is_write_i ? fgt_wr_i : fgt_rd_i)) begin rule = "R5"; return 6'd2; end
      if (ib) begin rule = "R6"; return ir; end
      if (el2_en_i && nv2_i && nv1_i && nv_i) begin rule = "R7"; return 6'd8; end
      rule = "R8"; return 6'd32;
    end
    if (ib) begin rule = "R6"; return ir; end
    rule = "R8";
    return (hh || e2h_i) ? 6'd16 : 6'd32;
  endfunction

  task automatic check_cycle();
    logic [5:0] v;
    #1;
    v = ref_verdict();
    chk(rule, verdict_o, v);
    chk("R9", {ec_o, trap_el_o}, v == 2 ? {6'h18, 2'd2} : v == 4 ? {6'h18, 2'd3} : 8'h0);
    chk("R7", mem_offset_o, v == 8 ? 12'h888 : 12'h0);
    chk("R10", rdata_o, is_write_i ? 64'h0 : v == 16 ? {62'b0, hyp_m} : v == 32 ? krn_m : 64'h0);
    chk("R12", {el2_trace_en_o, el0_trace_en_o}, {hyp_m[1], hyp_m[0] & tge_i});
    @(posedge clk_i);
    if (is_write_i && v == 16) hyp_m = wdata_i[1:0];
    if (is_write_i && v == 32) krn_m = (krn_m & ~MASK) | (wdata_i & MASK);
    @(negedge clk_i);
  endtask

  task automatic set_enc(input logic hyp);
    op0_i = 3; op1_i = hyp ? 3'd4 : 3'd0; crn_i = 1; crm_i = 2; op2_i = 3;
  endtask

  task automatic quiet(input logic [1:0] el);
    req_valid_i = 1; cur_el_i = el; is_write_i = 0; wdata_i = '0;
    el2_en_i = 1; el3_present_i = 1; halted_i = 0; sdd_i = 0; ite_en_i = 1;
    fgt2_en_i = 1; fgt_rd_i = 1; fgt_wr_i = 1; nv_i = 0; nv1_i = 0; nv2_i = 0;
    e2h_i = 0; tge_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 30000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    hyp_m = '0; krn_m = '0;
    quiet(2'd3); set_enc(1'b1); req_valid_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R11: both registers read zero after reset
    quiet(2'd3); set_enc(1'b1); #1 chk("R11", rdata_o, 64'h0);
    set_enc(1'b0); #1 chk("R11", rdata_o, 64'h0);
    @(negedge clk_i);
    // directed corners
    quiet(2'd3); set_enc(1'b1); is_write_i = 1; wdata_i = '1; check_cycle();   // R10 hyp write
    quiet(2'd3); set_enc(1'b1); check_cycle();                                  // R10 bits [63:2] zero
    quiet(2'd3); set_enc(1'b0); is_write_i = 1; wdata_i = '1; check_cycle();   // R10 mask
    quiet(2'd3); set_enc(1'b0); check_cycle();
    quiet(2'd2); set_enc(1'b0); e2h_i = 1; check_cycle();                      // R8 alias
    quiet(2'd1); set_enc(1'b0); halted_i = 1; sdd_i = 1; ite_en_i = 0; fgt2_en_i = 0; check_cycle(); // R4
    quiet(2'd1); set_enc(1'b0); fgt2_en_i = 0; ite_en_i = 0; check_cycle();    // R5 before R6
    quiet(2'd1); set_enc(1'b0); is_write_i = 1; fgt_wr_i = 0; check_cycle();   // R5 write bit
    quiet(2'd2); set_enc(1'b1); ite_en_i = 0; check_cycle();                   // R6 trap
    quiet(2'd1); set_enc(1'b0); nv_i = 1; nv1_i = 1; nv2_i = 1; check_cycle(); // R7
    quiet(2'd1); set_enc(1'b0); nv_i = 1; nv1_i = 1; nv2_i = 1; is_write_i = 1; wdata_i = '0; check_cycle(); // R7 no write
    quiet(2'd3); set_enc(1'b0); check_cycle();                                  // R10 still ones
    quiet(2'd1); set_enc(1'b1); nv_i = 1; check_cycle();                       // R3
    quiet(2'd0); set_enc(1'b0); check_cycle();                                  // R2
    quiet(2'd2); set_enc(1'b1); op2_i = 2; check_cycle();                      // R1 miss
    quiet(2'd3); set_enc(1'b1); tge_i = 1; check_cycle();                      // R12
    // random
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      set_enc(k < 5);
      if (k == 9) begin op1_i = 3'($urandom); crm_i = 4'($urandom); end
      req_valid_i   = ($urandom_range(0, 9) != 0);
      cur_el_i      = 2'($urandom);
      is_write_i    = 1'($urandom);
      wdata_i       = {$urandom, $urandom};
      el2_en_i      = 1'($urandom);
      el3_present_i = ($urandom_range(0, 3) != 0);
      halted_i      = ($urandom_range(0, 3) == 0);
      sdd_i         = 1'($urandom);
      ite_en_i      = ($urandom_range(0, 3) != 0);
      fgt2_en_i     = ($urandom_range(0, 3) != 0);
      fgt_rd_i      = ($urandom_range(0, 3) != 0);
      fgt_wr_i      = ($urandom_range(0, 3) != 0);
      nv_i          = 1'($urandom);
      nv1_i         = 1'($urandom);
      nv2_i         = 1'($urandom);
      e2h_i         = 1'($urandom);
      tge_i         = 1'($urandom);
      check_cycle();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule